// File: doc/BRIEF.md
# USB Endpoint Handshake and Toggle State

This block keeps, for every endpoint of a full-speed USB device controller, the state that decides how the device answers the host. It tracks whether firmware has asked for a STALL. It holds sticky flags for STALL and NAK handshakes that have already gone out, and the data toggle bit. A packet engine reports decoded events to it on a shared endpoint/type bus. These events are a token (OUT, IN or SETUP), a received data packet (its PID and whether it was accepted) and a handshake that was transmitted. During a token cycle the block answers combinationally whether that token must be stalled.

Firmware reaches the state through a strobe port. It selects an endpoint and pulses arm, clear, endpoint-reset or enable-write strobes. A separate read select returns the state of any endpoint. A single interrupt request combines every sticky flag with its per-endpoint enable bit.

Top module: `usb_ep_hs_top`

## Requirements
- R1: After `rst_n` low, or one cycle after `bus_rst` high, every endpoint reads back all zero (stall request, stall-sent, NAK-IN, NAK-OUT, toggle, enables) and `irq` is 0.
- R2: Once firmware arms a stall on an endpoint, `stall_resp` is 1 during any OUT or IN token (`tok_kind` 0 or 1) to that endpoint whose `ev_type` is control (0), bulk (2) or interrupt (3). The request stays set until firmware clears it.
- R3: A token whose `ev_type` is isochronous (1) never gets `stall_resp`, even when a stall is armed.
- R4: A transmitted STALL handshake (`hs_kind` 2) sets the endpoint's stall-sent flag. Only a firmware clear removes it, and a transmitted STALL in the same cycle as that clear leaves the flag set.
- R5: A SETUP token (`tok_kind` 2) with control type (0) is not stalled and clears the armed stall request. A SETUP token with any other type leaves the request armed and is stalled.
- R6: An accepted data packet sets the toggle when it is DATA0 (`dat_data1`=0) and clears it when it is DATA1. A packet that is not accepted leaves the toggle unchanged.
- R7: A firmware endpoint reset clears the toggle. A control-type SETUP token sets it, as if DATA0 had been taken.
- R8: A transmitted NAK (`hs_kind` 1) sets NAK-IN when `hs_in`=1 and NAK-OUT when `hs_in`=0. Both are sticky until a firmware clear, and a hardware set wins over a clear in the same cycle.
- R9: `irq` is the OR over all endpoints of stall-sent AND `fw_ie[0]`, NAK-IN AND `fw_ie[1]`, and NAK-OUT AND `fw_ie[2]`. The enables are written per endpoint with `fw_ie_wr`.
- R10: Events and firmware strobes aimed at one endpoint leave every other endpoint unchanged.
- R11: When a firmware arm and a control SETUP reach the same endpoint in the same cycle, the stall request ends up armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous USB bus reset, clears all endpoint state |
| ev_ep | input | EPW | Endpoint addressed by the current event |
| ev_type | input | 2 | Endpoint type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| tok_valid | input | 1 | Token received this cycle |
| tok_kind | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| stall_resp | output | 1 | Answer the current token with STALL |
| dat_valid | input | 1 | Data packet finished this cycle |
| dat_data1 | input | 1 | Packet PID was DATA1 (0 means DATA0) |
| dat_accept | input | 1 | Packet was accepted |
| hs_valid | input | 1 | Handshake transmitted this cycle |
| hs_kind | input | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| hs_in | input | 1 | Handshake answered an IN token |
| fw_ep | input | EPW | Endpoint selected by firmware strobes |
| fw_arm_stall | input | 1 | Arm stall request |
| fw_clr_stall | input | 1 | Clear stall request |
| fw_clr_stall_sent | input | 1 | Clear stall-sent flag |
| fw_clr_nak_in | input | 1 | Clear NAK-IN flag |
| fw_clr_nak_out | input | 1 | Clear NAK-OUT flag |
| fw_ep_reset | input | 1 | Endpoint reset, clears toggle |
| fw_ie_wr | input | 1 | Write interrupt enables |
| fw_ie | input | 3 | Enables: bit0 stall-sent, bit1 NAK-IN, bit2 NAK-OUT |
| rd_ep | input | EPW | Endpoint for read-back |
| rd_stall_req | output | 1 | Stall request of `rd_ep` |
| rd_stall_sent | output | 1 | Stall-sent flag of `rd_ep` |
| rd_nak_in | output | 1 | NAK-IN flag of `rd_ep` |
| rd_nak_out | output | 1 | NAK-OUT flag of `rd_ep` |
| rd_toggle | output | 1 | Toggle bit of `rd_ep` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the collisions, where a hardware event and a firmware strobe hit the same flag of the same endpoint in one cycle. Examples are a STALL sent while firmware clears stall-sent, a NAK while firmware clears NAK-IN, and a firmware arm together with a control SETUP. The bench reaches each of these by driving both strobes in the same clock. A rejected packet that lies between accepted ones of the opposite PID shows whether rejection really leaves the toggle alone. For that, the toggle sweep visits every combination of data PID and accept on every endpoint, in an order that puts such a packet there.

// File: rtl/usb_ephs_pkg.sv
package usb_ephs_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2
    } tok_kind_e;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_type_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_kind_e;

    localparam int IE_BITS = 3;

    typedef struct packed {
        logic ie_nak_out;
        logic ie_nak_in;
        logic ie_stall_sent;
        logic toggle;
        logic nak_out;
        logic nak_in;
        logic stall_sent;
        logic stall_req;
    } ep_state_t;

endpackage

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
    import usb_ephs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rst,
    input  logic [1:0]          ep_type,
    input  logic                tok_hit,
    input  logic [1:0]          tok_kind,
    input  logic                dat_hit,
    input  logic                dat_data1,
    input  logic                dat_accept,
    input  logic                hs_hit,
    input  logic [1:0]          hs_kind,
    input  logic                hs_in,
    input  logic                fw_hit,
    input  logic                fw_arm_stall,
    input  logic                fw_clr_stall,
    input  logic                fw_clr_stall_sent,
    input  logic                fw_clr_nak_in,
    input  logic                fw_clr_nak_out,
    input  logic                fw_ep_reset,
    input  logic                fw_ie_wr,
    input  logic [IE_BITS-1:0]  fw_ie,
    output ep_state_t           state_q,
    output logic                stall_hit
);

    ep_state_t state_d;

    logic setup_ctrl;
    logic hs_stall, hs_nak_in, hs_nak_out;
    logic fw_arm, fw_clr_req, fw_clr_ss, fw_clr_ni, fw_clr_no, fw_rst_ep;

    always_comb begin
        setup_ctrl = tok_hit && (tok_kind == TK_SETUP) && (ep_type == EP_CTRL);
        hs_stall   = hs_hit && (hs_kind == HS_STALL);
        hs_nak_in  = hs_hit && (hs_kind == HS_NAK) && hs_in;
        hs_nak_out = hs_hit && (hs_kind == HS_NAK) && !hs_in;
        fw_arm     = fw_hit && fw_arm_stall;
        fw_clr_req = fw_hit && fw_clr_stall;
        fw_clr_ss  = fw_hit && fw_clr_stall_sent;
        fw_clr_ni  = fw_hit && fw_clr_nak_in;
        fw_clr_no  = fw_hit && fw_clr_nak_out;
        fw_rst_ep  = fw_hit && fw_ep_reset;

        // Token answered with STALL: armed, not isochronous, not a control SETUP
        stall_hit = tok_hit && state_q.stall_req && (ep_type != EP_ISO) && !setup_ctrl;

        state_d = state_q;

        // Stall request: firmware arm dominates both clear sources
        state_d.stall_req = (state_q.stall_req && !fw_clr_req && !setup_ctrl) || fw_arm;

        // Sticky status: hardware set dominates firmware clear
        state_d.stall_sent = (state_q.stall_sent && !fw_clr_ss) || hs_stall;
        state_d.nak_in     = (state_q.nak_in     && !fw_clr_ni) || hs_nak_in;
        state_d.nak_out    = (state_q.nak_out    && !fw_clr_no) || hs_nak_out;

        // Toggle
        if (fw_rst_ep)
            state_d.toggle = 1'b0;
        if (setup_ctrl)
            state_d.toggle = 1'b1;
        if (dat_hit && dat_accept)
            state_d.toggle = !dat_data1;

        if (fw_hit && fw_ie_wr) begin
            state_d.ie_stall_sent = fw_ie[0];
            state_d.ie_nak_in     = fw_ie[1];
            state_d.ie_nak_out    = fw_ie[2];
        end

        if (bus_rst)
            state_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (state_q == '0));

    a_r4_stall_sent_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.stall_sent) |-> $past(hs_hit && (hs_kind == HS_STALL)));

    a_r5_setup_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_ctrl && !fw_arm) |=> !state_q.stall_req);

    a_r6_reject_keeps_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_hit && !dat_accept && !fw_rst_ep && !setup_ctrl && !bus_rst)
            |=> $stable(state_q.toggle));

    a_r8_nak_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.nak_in && !fw_clr_ni && !bus_rst) |=> state_q.nak_in);

    a_r8_nak_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.nak_out && !fw_clr_no && !bus_rst) |=> state_q.nak_out);

endmodule

// File: rtl/usb_ep_irq.sv
module usb_ep_irq
    import usb_ephs_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ep_state_t slot_q [SLOTS],
    output logic      irq
);

    logic [SLOTS-1:0] slot_req;
    logic [SLOTS-1:0] slot_any_ie;

    for (genvar i = 0; i < SLOTS; i++) begin : g_term
        assign slot_req[i] = (slot_q[i].stall_sent && slot_q[i].ie_stall_sent)
                           | (slot_q[i].nak_in     && slot_q[i].ie_nak_in)
                           | (slot_q[i].nak_out    && slot_q[i].ie_nak_out);
        assign slot_any_ie[i] = slot_q[i].ie_stall_sent | slot_q[i].ie_nak_in
                              | slot_q[i].ie_nak_out;
    end

    assign irq = |slot_req;

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_any_ie == '0) |-> !irq);

endmodule

// File: rtl/usb_ep_hs_top.sv
module usb_ep_hs_top
    import usb_ephs_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst,
    input  logic [EPW-1:0]     ev_ep,
    input  logic [1:0]         ev_type,
    input  logic               tok_valid,
    input  logic [1:0]         tok_kind,
    output logic               stall_resp,
    input  logic               dat_valid,
    input  logic               dat_data1,
    input  logic               dat_accept,
    input  logic               hs_valid,
    input  logic [1:0]         hs_kind,
    input  logic               hs_in,
    input  logic [EPW-1:0]     fw_ep,
    input  logic               fw_arm_stall,
    input  logic               fw_clr_stall,
    input  logic               fw_clr_stall_sent,
    input  logic               fw_clr_nak_in,
    input  logic               fw_clr_nak_out,
    input  logic               fw_ep_reset,
    input  logic               fw_ie_wr,
    input  logic [2:0]         fw_ie,
    input  logic [EPW-1:0]     rd_ep,
    output logic               rd_stall_req,
    output logic               rd_stall_sent,
    output logic               rd_nak_in,
    output logic               rd_nak_out,
    output logic               rd_toggle,
    output logic               irq
);

    localparam int EP_SLOTS = 2 ** EPW;

    ep_state_t           slot_q [EP_SLOTS];
    logic [EP_SLOTS-1:0] slot_stall;

    for (genvar i = 0; i < EP_SLOTS; i++) begin : g_ep
        localparam logic [EPW-1:0] IDX = EPW'(i);
        if (i < NUM_EP) begin : g_live
            usb_ep_slot u_slot (
                .clk               (clk),
                .rst_n             (rst_n),
                .bus_rst           (bus_rst),
                .ep_type           (ev_type),
                .tok_hit           (tok_valid && (ev_ep == IDX)),
                .tok_kind          (tok_kind),
                .dat_hit           (dat_valid && (ev_ep == IDX)),
                .dat_data1         (dat_data1),
                .dat_accept        (dat_accept),
                .hs_hit            (hs_valid && (ev_ep == IDX)),
                .hs_kind           (hs_kind),
                .hs_in             (hs_in),
                .fw_hit            (fw_ep == IDX),
                .fw_arm_stall      (fw_arm_stall),
                .fw_clr_stall      (fw_clr_stall),
                .fw_clr_stall_sent (fw_clr_stall_sent),
                .fw_clr_nak_in     (fw_clr_nak_in),
                .fw_clr_nak_out    (fw_clr_nak_out),
                .fw_ep_reset       (fw_ep_reset),
                .fw_ie_wr          (fw_ie_wr),
                .fw_ie             (fw_ie),
                .state_q           (slot_q[i]),
                .stall_hit         (slot_stall[i])
            );
        end else begin : g_absent
            assign slot_q[i]     = '0;
            assign slot_stall[i] = 1'b0;
        end
    end

    assign stall_resp = |slot_stall;

    ep_state_t rd_state;
    always_comb begin
        rd_state      = slot_q[rd_ep];
        rd_stall_req  = rd_state.stall_req;
        rd_stall_sent = rd_state.stall_sent;
        rd_nak_in     = rd_state.nak_in;
        rd_nak_out    = rd_state.nak_out;
        rd_toggle     = rd_state.toggle;
    end

    usb_ep_irq #(.SLOTS(EP_SLOTS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_q (slot_q),
        .irq    (irq)
    );

    a_r3_iso_never_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && (ev_type == EP_ISO)) |-> !stall_resp);

    a_r2_stall_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
        stall_resp |-> tok_valid);

endmodule

// File: tb/usb_ep_hs_top_test.sv
module usb_ep_hs_top_test;

    localparam int NEP = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_rst;
    logic [1:0] ev_ep;
    logic [1:0] ev_type;
    logic       tok_valid;
    logic [1:0] tok_kind;
    logic       stall_resp;
    logic       dat_valid, dat_data1, dat_accept;
    logic       hs_valid;
    logic [1:0] hs_kind;
    logic       hs_in;
    logic [1:0] fw_ep;
    logic       fw_arm_stall, fw_clr_stall, fw_clr_stall_sent;
    logic       fw_clr_nak_in, fw_clr_nak_out, fw_ep_reset, fw_ie_wr;
    logic [2:0] fw_ie;
    logic [1:0] rd_ep;
    logic       rd_stall_req, rd_stall_sent, rd_nak_in, rd_nak_out, rd_toggle;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic tog_m [NEP];

    usb_ep_hs_top #(.NUM_EP(NEP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .ev_ep(ev_ep), .ev_type(ev_type),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .stall_resp(stall_resp),
        .dat_valid(dat_valid), .dat_data1(dat_data1), .dat_accept(dat_accept),
        .hs_valid(hs_valid), .hs_kind(hs_kind), .hs_in(hs_in),
        .fw_ep(fw_ep), .fw_arm_stall(fw_arm_stall), .fw_clr_stall(fw_clr_stall),
        .fw_clr_stall_sent(fw_clr_stall_sent), .fw_clr_nak_in(fw_clr_nak_in),
        .fw_clr_nak_out(fw_clr_nak_out), .fw_ep_reset(fw_ep_reset),
        .fw_ie_wr(fw_ie_wr), .fw_ie(fw_ie),
        .rd_ep(rd_ep), .rd_stall_req(rd_stall_req), .rd_stall_sent(rd_stall_sent),
        .rd_nak_in(rd_nak_in), .rd_nak_out(rd_nak_out), .rd_toggle(rd_toggle),
        .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic idle();
        bus_rst = 0; ev_ep = 0; ev_type = 0; tok_valid = 0; tok_kind = 0;
        dat_valid = 0; dat_data1 = 0; dat_accept = 0;
        hs_valid = 0; hs_kind = 0; hs_in = 0;
        fw_ep = 0; fw_arm_stall = 0; fw_clr_stall = 0; fw_clr_stall_sent = 0;
        fw_clr_nak_in = 0; fw_clr_nak_out = 0; fw_ep_reset = 0;
        fw_ie_wr = 0; fw_ie = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // exp4 = {stall_req, stall_sent, nak_in, nak_out}; toggle from the model
    task automatic chk_ep(input int e, input string tag, input logic [3:0] exp4);
        rd_ep = 2'(e);
        #1;
        chk($sformatf("%s ep%0d", tag, e),
            int'({rd_stall_req, rd_stall_sent, rd_nak_in, rd_nak_out, rd_toggle}),
            int'({exp4, tog_m[e]}));
    endtask

    task automatic fw_arm(input int e);
        fw_ep = 2'(e); fw_arm_stall = 1; cyc(); fw_arm_stall = 0;
    endtask

    task automatic fw_unarm(input int e);
        fw_ep = 2'(e); fw_clr_stall = 1; cyc(); fw_clr_stall = 0;
    endtask

    task automatic send_hs(input int e, input int kind, input logic dir_in);
        ev_ep = 2'(e); hs_kind = 2'(kind); hs_in = dir_in; hs_valid = 1;
        cyc(); hs_valid = 0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int e = 0; e < NEP; e++) tog_m[e] = 0;
        idle();
        rd_ep = 0;
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();

        // R1: reset state
        for (int e = 0; e < NEP; e++) chk_ep(e, "R1 reset", 4'b0000);
        chk("R1 reset irq", int'(irq), 0);

        // R2 / R3 / R10: stall answer over every endpoint, type and direction
        for (int e = 0; e < NEP; e++) begin
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k < 2; k++) begin
                    fw_arm(e);
                    ev_type = 2'(t); tok_kind = 2'(k); tok_valid = 1;
                    ev_ep = 2'((e + 1) % NEP);
                    #1 chk("R10 other ep not stalled", int'(stall_resp), 0);
                    ev_ep = 2'(e);
                    #1 chk((t == 1) ? "R3 iso not stalled" : "R2 stalled",
                           int'(stall_resp), (t == 1) ? 0 : 1);
                    cyc(); tok_valid = 0;
                    chk_ep(e, "R2 request held", 4'b1000);
                    fw_unarm(e);
                    chk_ep(e, "R2 request cleared", 4'b0000);
                end
            end
        end

        // R4: stall-sent sticky, hardware set wins
        send_hs(2, 2, 1'b1);
        chk_ep(2, "R4 stall-sent set", 4'b0100);
        repeat (3) cyc();
        chk_ep(2, "R4 stall-sent sticky", 4'b0100);
        chk_ep(3, "R10 neighbour untouched", 4'b0000);
        fw_ep = 2; fw_clr_stall_sent = 1;
        send_hs(2, 2, 1'b0);
        fw_clr_stall_sent = 0;
        chk_ep(2, "R4 hw set beats clear", 4'b0100);
        fw_ep = 2; fw_clr_stall_sent = 1; cyc(); fw_clr_stall_sent = 0;
        chk_ep(2, "R4 firmware clear", 4'b0000);

        // R5: control SETUP clears request and is not stalled; bulk SETUP does not
        fw_arm(1);
        ev_ep = 1; ev_type = 0; tok_kind = 2; tok_valid = 1;
        #1 chk("R5 control SETUP not stalled", int'(stall_resp), 0);
        cyc(); tok_valid = 0;
        tog_m[1] = 1;
        chk_ep(1, "R5 request auto-cleared", 4'b0000);
        fw_arm(1);
        ev_ep = 1; ev_type = 2; tok_kind = 2; tok_valid = 1;
        #1 chk("R5 bulk SETUP stalled", int'(stall_resp), 1);
        cyc(); tok_valid = 0;
        chk_ep(1, "R5 bulk SETUP keeps request", 4'b1000);

        // R11: arm and control SETUP in the same cycle
        fw_unarm(1);
        fw_ep = 1; fw_arm_stall = 1;
        ev_ep = 1; ev_type = 0; tok_kind = 2; tok_valid = 1;
        cyc(); fw_arm_stall = 0; tok_valid = 0;
        chk_ep(1, "R11 arm wins over SETUP", 4'b1000);
        fw_unarm(1);

        // R6 / R10: toggle sweep
        for (int e = 0; e < NEP; e++) begin
            for (int d1 = 0; d1 < 2; d1++) begin
                for (int acc = 0; acc < 2; acc++) begin
                    ev_ep = 2'(e); dat_data1 = d1[0]; dat_accept = acc[0]; dat_valid = 1;
                    cyc(); dat_valid = 0;
                    if (acc != 0) tog_m[e] = (d1 == 0);
                    for (int o = 0; o < NEP; o++) chk_ep(o, "R6 toggle", 4'b0000);
                end
            end
        end

        // R7: endpoint reset and control SETUP on toggle
        ev_ep = 3; dat_data1 = 0; dat_accept = 1; dat_valid = 1;
        cyc(); dat_valid = 0; tog_m[3] = 1;
        chk_ep(3, "R7 precondition", 4'b0000);
        fw_ep = 3; fw_ep_reset = 1; cyc(); fw_ep_reset = 0; tog_m[3] = 0;
        chk_ep(3, "R7 endpoint reset", 4'b0000);
        ev_ep = 3; ev_type = 0; tok_kind = 2; tok_valid = 1;
        cyc(); tok_valid = 0; tog_m[3] = 1;
        chk_ep(3, "R7 SETUP forces toggle", 4'b0000);
        ev_ep = 0; ev_type = 2; tok_kind = 2; tok_valid = 1;
        cyc(); tok_valid = 0;
        chk_ep(0, "R7 bulk SETUP leaves toggle", 4'b0000);

        // R8: NAK flags per direction
        for (int e = 0; e < NEP; e++) begin
            send_hs(e, 1, 1'b1);
            chk_ep(e, "R8 NAK-IN set", 4'b0010);
            send_hs(e, 1, 1'b0);
            chk_ep(e, "R8 NAK-OUT set", 4'b0011);
            send_hs(e, 0, 1'b1);
            chk_ep(e, "R8 ACK no effect", 4'b0011);
            fw_ep = 2'(e); fw_clr_nak_in = 1; cyc(); fw_clr_nak_in = 0;
            chk_ep(e, "R8 NAK-IN cleared", 4'b0001);
            fw_ep = 2'(e); fw_clr_nak_out = 1; cyc(); fw_clr_nak_out = 0;
            chk_ep(e, "R8 NAK-OUT cleared", 4'b0000);
        end
        fw_ep = 0; fw_clr_nak_in = 1;
        send_hs(0, 1, 1'b1);
        fw_clr_nak_in = 0;
        chk_ep(0, "R8 hw set beats clear", 4'b0010);
        fw_ep = 0; fw_clr_nak_in = 1; cyc(); fw_clr_nak_in = 0;

        // R9: interrupt combination
        send_hs(1, 2, 1'b1);
        send_hs(1, 1, 1'b1);
        for (int m = 0; m < 8; m++) begin
            fw_ep = 1; fw_ie = 3'(m); fw_ie_wr = 1; cyc(); fw_ie_wr = 0;
            #1 chk("R9 irq stall-sent/nak-in", int'(irq), ((m & 3) != 0) ? 1 : 0);
        end
        send_hs(1, 1, 1'b0);
        for (int m = 0; m < 8; m++) begin
            fw_ep = 1; fw_ie = 3'(m); fw_ie_wr = 1; cyc(); fw_ie_wr = 0;
            #1 chk("R9 irq all flags", int'(irq), (m != 0) ? 1 : 0);
        end
        fw_ep = 1; fw_ie = 0; fw_ie_wr = 1; cyc();
        fw_ep = 2; fw_ie = 3'b100; cyc(); fw_ie_wr = 0;
        #1 chk("R9 enable without flag", int'(irq), 0);
        send_hs(2, 1, 1'b0);
        #1 chk("R9 nak-out on enabled ep", int'(irq), 1);

        // R1: bus reset
        bus_rst = 1; cyc(); bus_rst = 0;
        for (int e = 0; e < NEP; e++) tog_m[e] = 0;
        for (int e = 0; e < NEP; e++) chk_ep(e, "R1 bus reset", 4'b0000);
        chk("R1 bus reset irq", int'(irq), 0);
        send_hs(2, 1, 1'b0);
        #1 chk("R1 enables cleared by bus reset", int'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule